// File: doc/BRIEF.md
# Two-Wire Controller Interrupt Status and Clear Unit

This unit gathers the event indications of a master-only two-wire bus controller into one interrupt line. Twelve sources feed a raw status word. Ten of them are single-cycle pulses that are latched until software clears them. The other two, receive-FIFO-full and transmit-FIFO-empty, are levels that follow the FIFO condition directly. A software-written enable mask is ANDed with the raw word to form the masked status, and the interrupt output is the OR of that masked word.

Software clears latched events by reading. Each pulse source has its own clear address, so a handler clears only the bits it has already seen. An event that arrives between the status read and the clear is therefore kept. A global clear address clears all latched sources at once. When a transmit abort is signalled, a separate cause word collects the reasons that come with it. Reading the abort clear address also empties that cause word, so software must read the cause first.

The register port is combinational on reads: `rdata` is valid in the same cycle as `rd_en`, and any clear that the read causes takes effect at the following clock edge.

Top module: `twi_irq_unit`

## Requirements
- R1: After reset the raw status of the pulse sources, the mask and the abort-cause word are all zero, so `irq` is low.
- R2: A one-cycle pulse on a pulse source (src_i bits 0,1,3,5,6,7,8,9,10,11) sets that source's raw bit from the next cycle on. The bit stays set until it is cleared. The raw word is read at address 0x34, with bit order 0 RX underflow, 1 RX overflow, 2 RX full, 3 TX overflow, 4 TX empty, 5 read request, 6 TX abort, 7 RX done, 8 activity, 9 stop seen, 10 start seen, 11 general call.
- R3: The mask is written and read at 0x30. Only bits 11:0 are stored and the upper write bits are dropped. A read of 0x2C returns the raw word ANDed with the mask.
- R4: `irq` is high exactly when at least one raw bit is set whose mask bit is also set.
- R5: Each pulse source has a clear address 0x44 + 4*k, where k is its rank among the pulse sources from bit 0 upward (bit 0 at 0x44, bit 6 at 0x54, bit 7 at 0x58, bit 9 at 0x60). A read there returns the source's raw bit before the clear in rdata bit 0 and clears only that bit.
- R6: A read of 0x40 returns in bit 0 the OR of the raw word. It clears every latched pulse source and the abort-cause word.
- R7: If a source's pulse arrives in the same cycle as a read that clears it, the bit is set after that cycle.
- R8: The RX-full (bit 2) and TX-empty (bit 4) raw bits follow their src_i inputs in the same cycle. They have no clear address, and the global clear has no effect on them.
- R9: A TX-abort pulse (src_i bit 6) ORs `abort_src_i` into the abort-cause word, which is read at 0x80. The cause bits are: 0 seven-bit address not acknowledged, 1 and 2 first and second ten-bit address bytes not acknowledged, 3 data not acknowledged, 11 use while disabled, 12 arbitration lost.
- R10: A read of the TX-abort clear address 0x54 also empties the abort-cause word. If an abort pulse comes in the same cycle, the cause word holds just the new `abort_src_i` value.
- R11: A write to any address other than 0x30 changes no state, and a read of an unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Register read strobe; a clear takes effect at the next edge |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational, zero when rd_en is low |
| src_i | input | 12 | Event inputs: pulses, except bits 2 and 4, which are levels |
| abort_src_i | input | CAUSE_W | Abort reasons, valid with the TX-abort pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the pulse inputs are clean single-cycle events from the controller core, and that `abort_src_i` carries meaning only in a cycle where src_i bit 6 is high. They also assume that the two level inputs may stay high for any number of cycles. The bench drives every input at the falling edge. It raises each pulse for exactly one cycle, sets abort reasons only together with the abort pulse, and changes the level inputs only between register accesses. The one exception is deliberate: it places a pulse in the same cycle as the read that clears it, to exercise the case where the new event must win.

// File: rtl/twi_irq_pkg.sv
package twi_irq_pkg;

  localparam int NUM_SRC = 12;

  // source positions in the status word
  localparam int SRC_RX_UNDER  = 0;
  localparam int SRC_RX_OVER   = 1;
  localparam int SRC_RX_FULL   = 2;
  localparam int SRC_TX_OVER   = 3;
  localparam int SRC_TX_EMPTY  = 4;
  localparam int SRC_RD_REQ    = 5;
  localparam int SRC_TX_ABRT   = 6;
  localparam int SRC_RX_DONE   = 7;
  localparam int SRC_ACTIVITY  = 8;
  localparam int SRC_STOP_SEEN = 9;
  localparam int SRC_STRT_SEEN = 10;
  localparam int SRC_GEN_CALL  = 11;

  // sources that mirror a FIFO level rather than latch a pulse
  localparam logic [NUM_SRC-1:0] LEVEL_SRC =
    (NUM_SRC'(1) << SRC_RX_FULL) | (NUM_SRC'(1) << SRC_TX_EMPTY);
  localparam logic [NUM_SRC-1:0] EDGE_SRC = ~LEVEL_SRC;

  // register byte offsets
  localparam int OFS_MASKED   = 'h2C;
  localparam int OFS_MASK     = 'h30;
  localparam int OFS_RAW      = 'h34;
  localparam int OFS_CLR_ALL  = 'h40;
  localparam int OFS_CLR_BASE = 'h44;
  localparam int OFS_CAUSE    = 'h80;

  // abort cause bit positions
  localparam int CZ_ADDR7_NACK   = 0;
  localparam int CZ_ADDR10A_NACK = 1;
  localparam int CZ_ADDR10B_NACK = 2;
  localparam int CZ_DATA_NACK    = 3;
  localparam int CZ_DISABLED     = 11;
  localparam int CZ_ARB_LOST     = 12;

  function automatic bit src_is_level(input int idx);
    return LEVEL_SRC[idx];
  endfunction

  // position of a pulse source among the pulse sources only
  function automatic int clr_rank(input int idx);
    int r;
    r = 0;
    for (int j = 0; j < NUM_SRC; j++) begin
      if (j < idx && !LEVEL_SRC[j]) r++;
    end
    return r;
  endfunction

  function automatic int clr_offset(input int idx);
    return OFS_CLR_BASE + 4 * clr_rank(idx);
  endfunction

endpackage

// File: rtl/twi_irq_decode.sv
module twi_irq_decode
  import twi_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_masked,
  output logic              hit_mask,
  output logic              hit_raw,
  output logic              hit_clr_all,
  output logic              hit_cause,
  output logic [NUM_SRC-1:0] hit_clr,
  output logic [NUM_SRC-1:0] clr_vec,
  output logic              clr_all,
  output logic              mask_we
);

  assign hit_masked  = (addr == ADDR_W'(OFS_MASKED));
  assign hit_mask    = (addr == ADDR_W'(OFS_MASK));
  assign hit_raw     = (addr == ADDR_W'(OFS_RAW));
  assign hit_clr_all = (addr == ADDR_W'(OFS_CLR_ALL));
  assign hit_cause   = (addr == ADDR_W'(OFS_CAUSE));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
    if (src_is_level(i)) begin : g_none
      assign hit_clr[i] = 1'b0;
    end else begin : g_addr
      assign hit_clr[i] = (addr == ADDR_W'(clr_offset(i)));
    end
  end

  assign clr_vec = hit_clr & {NUM_SRC{rd_en}};
  assign clr_all = rd_en & hit_clr_all;
  assign mask_we = wr_en & hit_mask;

endmodule

// File: rtl/twi_irq_srcbit.sv
module twi_irq_srcbit #(
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  if (IS_LEVEL) begin : g_level
    logic unused_lvl;
    assign unused_lvl = clk ^ rst_n ^ clr_i;
    assign q_o = set_i;
  end else begin : g_latch
    logic q_r;
    // a new event has priority over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_r <= 1'b0;
      else if (set_i)  q_r <= 1'b1;
      else if (clr_i)  q_r <= 1'b0;
    end
    assign q_o = q_r;
  end

endmodule

// File: rtl/twi_irq_cause.sv
module twi_irq_cause #(
  parameter int CAUSE_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture_i,
  input  logic [CAUSE_W-1:0] reason_i,
  input  logic               wipe_i,
  output logic [CAUSE_W-1:0] cause_o
);

  logic [CAUSE_W-1:0] cause_r;

  function automatic logic [CAUSE_W-1:0] next_cause(
    input logic [CAUSE_W-1:0] cur,
    input logic               cap,
    input logic [CAUSE_W-1:0] rsn,
    input logic               wipe
  );
    logic [CAUSE_W-1:0] base;
    base = wipe ? '0 : cur;
    return cap ? (base | rsn) : base;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_r <= '0;
    else        cause_r <= next_cause(cause_r, capture_i, reason_i, wipe_i);
  end

  assign cause_o = cause_r;

endmodule

// File: rtl/twi_irq_unit.sv
module twi_irq_unit
  import twi_irq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int CAUSE_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [11:0]        src_i,
  input  logic [CAUSE_W-1:0] abort_src_i,
  output logic               irq
);

  localparam int N = NUM_SRC;

  logic              hit_masked, hit_mask, hit_raw, hit_clr_all, hit_cause;
  logic [N-1:0]      hit_clr;
  logic [N-1:0]      clr_vec;
  logic              clr_all;
  logic              mask_we;
  logic [N-1:0]      raw_stat;
  logic [N-1:0]      mask_q;
  logic [N-1:0]      masked_stat;
  logic [CAUSE_W-1:0] cause_q;
  logic              cause_wipe;
  logic              unused_wdata;

  twi_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .addr        (addr),
    .hit_masked  (hit_masked),
    .hit_mask    (hit_mask),
    .hit_raw     (hit_raw),
    .hit_clr_all (hit_clr_all),
    .hit_cause   (hit_cause),
    .hit_clr     (hit_clr),
    .clr_vec     (clr_vec),
    .clr_all     (clr_all),
    .mask_we     (mask_we)
  );

  for (genvar i = 0; i < N; i++) begin : g_src
    twi_irq_srcbit #(.IS_LEVEL(src_is_level(i))) u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (src_i[i]),
      .clr_i (clr_vec[i] | clr_all),
      .q_o   (raw_stat[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= wdata[N-1:0];
  end

  assign unused_wdata = ^wdata[DATA_W-1:N];

  assign cause_wipe = clr_vec[SRC_TX_ABRT] | clr_all;

  twi_irq_cause #(.CAUSE_W(CAUSE_W)) u_cause (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (src_i[SRC_TX_ABRT]),
    .reason_i  (abort_src_i),
    .wipe_i    (cause_wipe),
    .cause_o   (cause_q)
  );

  assign masked_stat = raw_stat & mask_q;
  assign irq         = |masked_stat;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (hit_masked)  rdata = DATA_W'(masked_stat);
      if (hit_mask)    rdata = DATA_W'(mask_q);
      if (hit_raw)     rdata = DATA_W'(raw_stat);
      if (hit_cause)   rdata = DATA_W'(cause_q);
      if (hit_clr_all) rdata = DATA_W'(|raw_stat);
      for (int i = 0; i < N; i++) begin
        if (hit_clr[i]) rdata = DATA_W'(raw_stat[i]);
      end
    end
  end

endmodule

// File: rtl/twi_irq_chk.sv
module twi_irq_chk
  import twi_irq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CAUSE_W = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic [11:0]        src_i,
  input logic [11:0]        raw_stat,
  input logic [11:0]        mask_q,
  input logic [CAUSE_W-1:0] cause_q,
  input logic               irq,
  input logic [11:0]        clr_vec,
  input logic               clr_all
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (mask_q == '0 && cause_q == '0 && (raw_stat & EDGE_SRC) == '0));

  assert_pulse_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_i & EDGE_SRC) != '0) |=>
      ((raw_stat & $past(src_i & EDGE_SRC)) == $past(src_i & EDGE_SRC)));

  assert_irq_needs_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (mask_q != '0));

  assert_clear_hits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~src_i & EDGE_SRC) != '0) |=>
      ((raw_stat & $past(clr_vec & ~src_i & EDGE_SRC)) == '0));

  assert_clear_spares_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_all |=>
      ((raw_stat & $past(raw_stat & ~clr_vec & EDGE_SRC)) == $past(raw_stat & ~clr_vec & EDGE_SRC)));

  assert_global_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && src_i == '0) |=> ((raw_stat & EDGE_SRC) == '0 && cause_q == '0));

  assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & src_i) != '0) |=>
      ((raw_stat & $past(clr_vec & src_i)) == $past(clr_vec & src_i)));

  assert_level_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_stat & LEVEL_SRC) == (src_i & LEVEL_SRC)));

  assert_cause_wipe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec[SRC_TX_ABRT] && !src_i[SRC_TX_ABRT]) |=> (cause_q == '0));

endmodule

bind twi_irq_unit twi_irq_chk #(.ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W)) u_chk (.*);

// File: tb/sim_twi_irq_unit.sv
module sim_twi_irq_unit;

  logic        clk = 1'b0;
  logic        rst_n, rd_en, wr_en;
  logic [7:0]  addr;
  logic [15:0] wdata, rdata;
  logic [11:0] src_i;
  logic [12:0] abort_src_i;
  logic        irq;
  logic [11:0] lvl;

  typedef struct {
    bit          is_irq;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 1'b0;

  always #5 clk = ~clk;

  twi_irq_unit u0 (
    .clk (clk), .rst_n (rst_n), .rd_en (rd_en), .wr_en (wr_en),
    .addr (addr), .wdata (wdata), .rdata (rdata),
    .src_i (src_i), .abort_src_i (abort_src_i), .irq (irq)
  );

  task automatic drive(input bit r, input bit w, input logic [7:0] a,
                       input logic [15:0] d, input logic [11:0] p, input logic [12:0] c);
    @(negedge clk);
    rd_en = r; wr_en = w; addr = a; wdata = d;
    src_i = p | lvl; abort_src_i = c;
  endtask

  task automatic idle();
    drive(0, 0, 8'h00, 16'h0, 12'h0, 13'h0);
  endtask

  task automatic pulse(input logic [11:0] p, input logic [12:0] c);
    drive(0, 0, 8'h00, 16'h0, p, c);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    drive(0, 1, a, d, 12'h0, 13'h0);
  endtask

  task automatic rd_ev(input logic [7:0] a, input logic [11:0] p, input logic [12:0] c,
                       input logic [15:0] e, input string tag);
    drive(1, 0, a, 16'h0, p, c);
    sbq.push_back('{1'b0, e, tag});
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] e, input string tag);
    rd_ev(a, 12'h0, 13'h0, e, tag);
  endtask

  task automatic chk_irq(input bit e, input string tag);
    idle();
    sbq.push_back('{1'b1, {15'h0, e}, tag});
  endtask

  // monitor: compares one queued expectation per cycle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sbq.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = sbq.pop_front();
        act = it.is_irq ? {15'h0, irq} : rdata;
        n_chk++;
        if (act !== it.exp) begin
          n_err++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    src_i = '0; abort_src_i = '0; lvl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h34, 16'h0000, "R1 raw after reset");
    rd(8'h30, 16'h0000, "R1 mask after reset");
    rd(8'h80, 16'h0000, "R1 cause after reset");
    chk_irq(1'b0, "R1 irq after reset");

    // R2 latch, R3 masking, R4 irq
    pulse(12'h201, 13'h0);
    rd(8'h34, 16'h0201, "R2 raw latched");
    rd(8'h2C, 16'h0000, "R3 masked with zero mask");
    chk_irq(1'b0, "R4 irq low when masked off");
    wr(8'h30, 16'h0200);
    rd(8'h30, 16'h0200, "R3 mask readback");
    rd(8'h2C, 16'h0200, "R3 masked status");
    chk_irq(1'b1, "R4 irq high");

    // R5 per-source clear
    rd(8'h60, 16'h0001, "R5 stop clear returns prior bit");
    rd(8'h34, 16'h0001, "R5 only stop bit cleared");
    chk_irq(1'b0, "R4 irq drops after clear");
    rd(8'h48, 16'h0000, "R5 clear of idle source");
    rd(8'h34, 16'h0001, "R5 other bit kept");

    // R6 global clear
    pulse(12'h828, 13'h0);
    rd(8'h34, 16'h0829, "R2 several sources");
    rd(8'h40, 16'h0001, "R6 global clear returns any");
    rd(8'h34, 16'h0000, "R6 all cleared");

    // R7 same-cycle event and clear
    rd_ev(8'h58, 12'h080, 13'h0, 16'h0000, "R7 clear read sees prior zero");
    rd(8'h34, 16'h0080, "R7 new event kept");
    rd(8'h58, 16'h0001, "R5 rx done clear");
    rd(8'h34, 16'h0000, "R5 rx done gone");

    // R8 level sources
    lvl = 12'h004;
    idle();
    rd(8'h34, 16'h0004, "R8 level visible");
    wr(8'h30, 16'h0004);
    chk_irq(1'b1, "R8 level raises irq");
    rd(8'h40, 16'h0001, "R8 global clear read");
    rd(8'h34, 16'h0004, "R8 clear has no effect on level");
    lvl = 12'h010;
    idle();
    rd(8'h34, 16'h0010, "R8 tx empty level");
    lvl = 12'h000;
    idle();
    rd(8'h34, 16'h0000, "R8 level released");
    chk_irq(1'b0, "R8 irq follows level");

    // R9 abort cause
    wr(8'h30, 16'h0040);
    pulse(12'h040, 13'h1001);
    rd(8'h80, 16'h1001, "R9 cause captured");
    rd(8'h34, 16'h0040, "R9 abort raw bit");
    chk_irq(1'b1, "R4 abort irq");
    pulse(12'h040, 13'h0008);
    rd(8'h80, 16'h1009, "R9 cause accumulates");

    // R10 abort clear wipes cause
    rd(8'h54, 16'h0001, "R10 abort clear returns prior");
    rd(8'h80, 16'h0000, "R10 cause wiped");
    rd(8'h34, 16'h0000, "R10 abort bit cleared");
    rd_ev(8'h54, 12'h040, 13'h0800, 16'h0000, "R10 same-cycle abort read");
    rd(8'h80, 16'h0800, "R10 new cause kept");
    rd(8'h34, 16'h0040, "R7 abort bit kept");
    rd(8'h40, 16'h0001, "R6 global clear with abort");
    rd(8'h80, 16'h0000, "R6 global clear wipes cause");

    // R11 writes elsewhere ignored
    pulse(12'h001, 13'h0);
    wr(8'h34, 16'h0000);
    wr(8'h80, 16'h1FFF);
    wr(8'h2C, 16'h0FFF);
    wr(8'h44, 16'h0000);
    rd(8'h34, 16'h0001, "R11 raw unchanged by writes");
    rd(8'h80, 16'h0000, "R11 cause unchanged by writes");
    rd(8'h30, 16'h0040, "R11 mask unchanged by writes");
    rd(8'h3C, 16'h0000, "R11 unmapped read is zero");
    rd(8'h44, 16'h0001, "R5 rx underflow clear");

    // R3 upper mask bits dropped
    wr(8'h30, 16'hFFFF);
    rd(8'h30, 16'h0FFF, "R3 mask upper bits dropped");

    repeat (3) idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule